// File: doc/BRIEF.md
# DRAM Command Spacing Guard

This block sits beside the command path of a four-bank DRAM controller and watches every command that goes to the device. It keeps one group of down-counters per bank and a few counters shared by all banks. For the command and bank presented at its input, it gives a vector that says which command types could be issued legally in the current cycle. When a command that breaks a spacing or state rule is actually issued, it latches a violation flag. The flag keeps a code for the broken rule and the bank it concerns, and holds them until the clear input is raised.

All timing minima are given as picosecond parameters together with the clock period. The block turns each one into whole cycles by dividing and rounding up. The defaults describe a 250 MHz device. Write-to-read turnaround, the fixed auto-precharge write recovery and the mode-set gap are given directly in cycles. The write activate-to-column delay is derived from the read one. The block also tracks how long each bank stays open against a maximum, and tracks refresh credit against the average refresh interval. The command input is an observation only: the block never stalls the stream, so there is no ready signal and no back-pressure. A command issued while its allow bit is low is still taken as issued and updates the bank state.

Top module: `dram_cmd_spacing_guard`

## Requirements
- R1: Command codes are NOP 0, ACT 1, RD 2, RDA 3, WR 4, WRA 5, PRE 6, PREA 7, REF 8, MRS 9, and allow bit i refers to code i. A command issued while its allow bit is low sets the violation flag on the next cycle. A command issued while its allow bit is high sets nothing.
- R2: ACT opens a bank. ACT to an open bank is code 1. RD, RDA, WR or WRA to an idle bank is code 2. PRE to an idle bank is ignored, and the bank can be activated on the next cycle.
- R3: RD or RDA needs 4 cycles after ACT to its bank (ceil of 16 ns at 4 ns). WR or WRA needs max(2, read delay - 2) = 2 cycles. A shorter gap is code 5.
- R4: Two ACTs to different banks need at least 3 cycles between them (ceil of 10 ns). A shorter gap is code 4.
- R5: PRE needs 8 cycles after ACT (tRAS), else code 7. An ACT needs 4 cycles after PRE or RDA to its bank, and the tRC of 12 cycles since its previous ACT, else code 3.
- R6: A read needs 4 cycles after a write: the last write data comes 2 cycles after the write command, and 2 more cycles follow. A shorter gap is code 6. Reads that follow reads may come on consecutive cycles.
- R7: PRE needs 2 + 4 = 6 cycles after WR (ceil of 15 ns recovery), else code 7. After WRA, ACT needs 2 + 3 + 4 = 9 cycles (fixed 3-cycle recovery plus tRP), else code 3.
- R8: MRS needs every bank idle with tRP elapsed, else code 8. For 2 cycles after MRS, any non-NOP command is code 9.
- R9: REF needs every bank idle with tRP elapsed, else code 8. For 14 cycles after REF, any non-NOP command is code 10.
- R10: After reset the flag, code and bank are 0. The first violation is kept, with its code and bank, and later violations do not change it. Clear drops the flag, code and bank to 0 on the next cycle.
- R11: A bank still open more than ceil(TRAS_MAX/tCK) cycles after its ACT raises code 11 with that bank.
- R12: One refresh credit accrues every ceil(TREFI/tCK) cycles, and each REF repays one. Accruing a credit while REF_POSTPONE credits are already owed raises code 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd | input | 4 | Command code (see R1) |
| bank | input | 2 | Target bank |
| clr | input | 1 | Clears the latched violation |
| allow | output | 10 | Per-command legality for the presented bank |
| viol | output | 1 | Sticky violation flag |
| viol_code | output | 4 | Code of the first violation |
| viol_bank | output | 2 | Bank of the first violation |

## Verification
A bank counter that is loaded or decremented wrongly shows up at once on the allow vector. The bit for the dependent command flips one cycle early or late, and the violation flag follows one cycle after the offending command. Each spacing rule is therefore swept across every gap from one cycle up to one past its minimum, so that an off-by-one in either direction changes a flag or a code. A wrong open/idle bit shows up as code 1 or 2 on the first column or activate command that follows. A wrong refresh or open-time counter shows up only when its window ends, so those two are checked at their exact expiry cycle or with a narrow margin.

// File: rtl/dcsg_pkg.sv
package dcsg_pkg;

  localparam int NCMD = 10;

  typedef enum logic [3:0] {
    C_NOP  = 4'd0,
    C_ACT  = 4'd1,
    C_RD   = 4'd2,
    C_RDA  = 4'd3,
    C_WR   = 4'd4,
    C_WRA  = 4'd5,
    C_PRE  = 4'd6,
    C_PREA = 4'd7,
    C_REF  = 4'd8,
    C_MRS  = 4'd9
  } cmd_e;

  typedef enum logic [3:0] {
    V_NONE      = 4'd0,
    V_ACT_OPEN  = 4'd1,
    V_COL_IDLE  = 4'd2,
    V_ACT_EARLY = 4'd3,
    V_RRD       = 4'd4,
    V_RCD       = 4'd5,
    V_CDLR      = 4'd6,
    V_PRE_EARLY = 4'd7,
    V_NOT_IDLE  = 4'd8,
    V_MRD       = 4'd9,
    V_RFC       = 4'd10,
    V_RAS_MAX   = 4'd11,
    V_REF_LATE  = 4'd12
  } viol_e;

  // nanosecond-style minimum to whole cycles, rounded up, at least one
  function automatic int ps2cyc(input int ps, input int tck);
    int n;
    n = (ps + tck - 1) / tck;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dcsg_bank_timer.sv
module dcsg_bank_timer
  import dcsg_pkg::*;
#(
  parameter int CW      = 6,
  parameter int AW      = 16,
  parameter int RC      = 12,
  parameter int RCD_RD  = 4,
  parameter int RCD_WR  = 2,
  parameter int RAS     = 8,
  parameter int RP      = 4,
  parameter int WREC    = 4,
  parameter int DAL     = 7,
  parameter int WLAST   = 2,
  parameter int RAS_MAX = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic wr_i,
  input  logic wra_i,
  input  logic rda_i,
  input  logic pre_i,
  output logic open_o,
  output logic act_rdy_o,
  output logic rd_rdy_o,
  output logic wr_rdy_o,
  output logic pre_rdy_o,
  output logic ras_over_o
);

  logic [CW-1:0] act_c, rcdr_c, rcdw_c, pre_c;
  logic [CW-1:0] act_n, rcdr_n, rcdw_n, pre_n;
  logic          open_q, open_n;
  logic [AW-1:0] age_q;

  always_comb begin
    int a_d, r_d, w_d, p_d, p_now;
    a_d   = (act_c  == '0) ? 0 : int'(act_c)  - 1;
    r_d   = (rcdr_c == '0) ? 0 : int'(rcdr_c) - 1;
    w_d   = (rcdw_c == '0) ? 0 : int'(rcdw_c) - 1;
    p_d   = (pre_c  == '0) ? 0 : int'(pre_c)  - 1;
    p_now = int'(pre_c);
    act_n  = CW'(a_d);
    rcdr_n = CW'(r_d);
    rcdw_n = CW'(w_d);
    pre_n  = CW'(p_d);
    open_n = open_q;
    if (act_i) begin
      open_n = 1'b1;
      act_n  = CW'(RC - 1);
      rcdr_n = CW'(RCD_RD - 1);
      rcdw_n = CW'(RCD_WR - 1);
      pre_n  = CW'(RAS - 1);
    end else if (wr_i || wra_i) begin
      // write recovery from the last data beat
      pre_n = CW'(imax(p_d, WLAST + WREC - 1));
      if (wra_i) begin
        open_n = 1'b0;
        act_n  = CW'(imax(imax(a_d, p_now + RP - 1), WLAST + DAL - 1));
      end
    end else if (rda_i) begin
      open_n = 1'b0;
      act_n  = CW'(imax(a_d, p_now + RP - 1));
    end else if (pre_i && open_q) begin
      open_n = 1'b0;
      act_n  = CW'(imax(a_d, RP - 1));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_c  <= '0;
      rcdr_c <= '0;
      rcdw_c <= '0;
      pre_c  <= '0;
      open_q <= 1'b0;
      age_q  <= '0;
    end else begin
      act_c  <= act_n;
      rcdr_c <= rcdr_n;
      rcdw_c <= rcdw_n;
      pre_c  <= pre_n;
      open_q <= open_n;
      if (act_i)
        age_q <= '0;
      else if (open_q && age_q != AW'(RAS_MAX + 1))
        age_q <= age_q + 1'b1;
    end
  end

  assign open_o     = open_q;
  assign act_rdy_o  = (act_c  == '0);
  assign rd_rdy_o   = (rcdr_c == '0);
  assign wr_rdy_o   = (rcdw_c == '0);
  assign pre_rdy_o  = (pre_c  == '0);
  assign ras_over_o = open_q && (age_q == AW'(RAS_MAX));

  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |=> open_q);
  p_pre_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_i && !act_i) |=> !open_q);
  p_wr_before_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rcdw_c <= rcdr_c);

endmodule

// File: rtl/dcsg_global_timer.sv
module dcsg_global_timer
  import dcsg_pkg::*;
#(
  parameter int CW       = 6,
  parameter int RRD      = 3,
  parameter int W2R      = 4,
  parameter int MRD      = 2,
  parameter int RFC      = 14,
  parameter int REFI     = 1950,
  parameter int POSTPONE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic wr_i,
  input  logic mrs_i,
  input  logic ref_i,
  output logic rrd_rdy_o,
  output logic w2r_rdy_o,
  output logic mrd_rdy_o,
  output logic rfc_rdy_o,
  output logic ref_late_o
);

  localparam int RW = $clog2(REFI + 1);
  localparam int DW = $clog2(POSTPONE + 2);

  logic [CW-1:0] rrd_c, w2r_c, mrd_c, rfc_c;
  logic [RW-1:0] refi_c;
  logic [DW-1:0] debt_q;
  logic          tick;

  assign tick = (refi_c == RW'(REFI - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrd_c  <= '0;
      w2r_c  <= '0;
      mrd_c  <= '0;
      rfc_c  <= '0;
      refi_c <= '0;
      debt_q <= '0;
    end else begin
      rrd_c <= act_i ? CW'(RRD - 1) : (rrd_c == '0 ? '0 : rrd_c - 1'b1);
      w2r_c <= wr_i  ? CW'(W2R - 1) : (w2r_c == '0 ? '0 : w2r_c - 1'b1);
      mrd_c <= mrs_i ? CW'(MRD - 1) : (mrd_c == '0 ? '0 : mrd_c - 1'b1);
      rfc_c <= ref_i ? CW'(RFC - 1) : (rfc_c == '0 ? '0 : rfc_c - 1'b1);
      refi_c <= tick ? '0 : refi_c + 1'b1;
      if (tick && !ref_i) begin
        if (debt_q <= DW'(POSTPONE)) debt_q <= debt_q + 1'b1;
      end else if (!tick && ref_i && debt_q != '0) begin
        debt_q <= debt_q - 1'b1;
      end
    end
  end

  assign rrd_rdy_o  = (rrd_c == '0);
  assign w2r_rdy_o  = (w2r_c == '0);
  assign mrd_rdy_o  = (mrd_c == '0);
  assign rfc_rdy_o  = (rfc_c == '0);
  assign ref_late_o = tick && !ref_i && (debt_q == DW'(POSTPONE));

  p_debt_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    debt_q <= DW'(POSTPONE + 1));

endmodule

// File: rtl/dcsg_rule_check.sv
module dcsg_rule_check
  import dcsg_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int BW    = 2
) (
  input  logic [3:0]       cmd_i,
  input  logic [BW-1:0]    bank_i,
  input  logic [NBANK-1:0] open_i,
  input  logic [NBANK-1:0] act_rdy_i,
  input  logic [NBANK-1:0] rd_rdy_i,
  input  logic [NBANK-1:0] wr_rdy_i,
  input  logic [NBANK-1:0] pre_rdy_i,
  input  logic             rrd_rdy_i,
  input  logic             w2r_rdy_i,
  input  logic             mrd_rdy_i,
  input  logic             rfc_rdy_i,
  output logic [NCMD-1:0]  allow_o,
  output viol_e            code_o
);

  logic all_quiet, prea_ok;

  always_comb begin
    all_quiet = 1'b1;
    prea_ok   = 1'b1;
    for (int b = 0; b < NBANK; b++) begin
      if (open_i[b] || !act_rdy_i[b]) all_quiet = 1'b0;
      if (open_i[b] && !pre_rdy_i[b]) prea_ok   = 1'b0;
    end
  end

  always_comb begin
    viol_e cause;
    code_o = V_NONE;
    for (int c = 0; c < NCMD; c++) begin
      cause = V_NONE;
      if (cmd_e'(4'(c)) != C_NOP) begin
        if (!mrd_rdy_i)      cause = V_MRD;
        else if (!rfc_rdy_i) cause = V_RFC;
        else begin
          case (cmd_e'(4'(c)))
            C_ACT: begin
              if (open_i[bank_i])          cause = V_ACT_OPEN;
              else if (!act_rdy_i[bank_i]) cause = V_ACT_EARLY;
              else if (!rrd_rdy_i)         cause = V_RRD;
            end
            C_RD, C_RDA: begin
              if (!open_i[bank_i])        cause = V_COL_IDLE;
              else if (!rd_rdy_i[bank_i]) cause = V_RCD;
              else if (!w2r_rdy_i)        cause = V_CDLR;
            end
            C_WR, C_WRA: begin
              if (!open_i[bank_i])        cause = V_COL_IDLE;
              else if (!wr_rdy_i[bank_i]) cause = V_RCD;
            end
            C_PRE: begin
              if (open_i[bank_i] && !pre_rdy_i[bank_i]) cause = V_PRE_EARLY;
            end
            C_PREA: begin
              if (!prea_ok) cause = V_PRE_EARLY;
            end
            C_REF, C_MRS: begin
              if (!all_quiet) cause = V_NOT_IDLE;
            end
            default: cause = V_NONE;
          endcase
        end
      end
      allow_o[c] = (cause == V_NONE);
      if (4'(c) == cmd_i) code_o = cause;
    end
  end

endmodule

// File: rtl/dram_cmd_spacing_guard.sv
module dram_cmd_spacing_guard
  import dcsg_pkg::*;
#(
  parameter int NBANK        = 4,
  parameter int TCK_PS       = 4000,
  parameter int TRC_PS       = 48000,
  parameter int TRFC_PS      = 56000,
  parameter int TRAS_PS      = 32000,
  parameter int TRCD_RD_PS   = 16000,
  parameter int TRP_PS       = 16000,
  parameter int TRRD_PS      = 10000,
  parameter int TWR_PS       = 15000,
  parameter int WR_AP_CYC    = 3,
  parameter int W2R_CYC      = 2,
  parameter int MRD_CYC      = 2,
  parameter int WLAST_CYC    = 2,
  parameter int TRAS_MAX_PS  = 100000000,
  parameter int TREFI_PS     = 7800000,
  parameter int REF_POSTPONE = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [3:0]               cmd,
  input  logic [$clog2(NBANK)-1:0] bank,
  input  logic                     clr,
  output logic [NCMD-1:0]          allow,
  output logic                     viol,
  output logic [3:0]               viol_code,
  output logic [$clog2(NBANK)-1:0] viol_bank
);

  localparam int BW      = $clog2(NBANK);
  localparam int RC      = ps2cyc(TRC_PS, TCK_PS);
  localparam int RFC     = ps2cyc(TRFC_PS, TCK_PS);
  localparam int RAS     = ps2cyc(TRAS_PS, TCK_PS);
  localparam int RCD_RD  = ps2cyc(TRCD_RD_PS, TCK_PS);
  localparam int RCD_WR  = imax(2, RCD_RD - 2);
  localparam int RP      = ps2cyc(TRP_PS, TCK_PS);
  localparam int RRD     = ps2cyc(TRRD_PS, TCK_PS);
  localparam int WREC    = ps2cyc(TWR_PS, TCK_PS);
  localparam int DAL     = WR_AP_CYC + RP;
  localparam int W2R     = WLAST_CYC + W2R_CYC;
  localparam int RAS_MAX = ps2cyc(TRAS_MAX_PS, TCK_PS);
  localparam int REFI    = ps2cyc(TREFI_PS, TCK_PS);
  localparam int CW      = $clog2(RC + RFC + RAS + RP + DAL + WLAST_CYC + WREC + W2R + MRD_CYC + RRD + 4);
  localparam int AW      = $clog2(RAS_MAX + 2);

  logic [NBANK-1:0] open_v, act_rdy_v, rd_rdy_v, wr_rdy_v, pre_rdy_v, ras_over_v;
  logic rrd_rdy, w2r_rdy, mrd_rdy, rfc_rdy, ref_late;
  logic is_act, is_wr_any, is_mrs, is_ref, is_prea;
  viol_e code_c;

  assign is_act    = cmd_valid && (cmd_e'(cmd) == C_ACT);
  assign is_wr_any = cmd_valid && (cmd_e'(cmd) == C_WR || cmd_e'(cmd) == C_WRA);
  assign is_mrs    = cmd_valid && (cmd_e'(cmd) == C_MRS);
  assign is_ref    = cmd_valid && (cmd_e'(cmd) == C_REF);
  assign is_prea   = cmd_valid && (cmd_e'(cmd) == C_PREA);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic sel;
    assign sel = cmd_valid && (bank == BW'(b));
    dcsg_bank_timer #(
      .CW(CW), .AW(AW), .RC(RC), .RCD_RD(RCD_RD), .RCD_WR(RCD_WR), .RAS(RAS),
      .RP(RP), .WREC(WREC), .DAL(DAL), .WLAST(WLAST_CYC), .RAS_MAX(RAS_MAX)
    ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .act_i      (sel && cmd_e'(cmd) == C_ACT),
      .wr_i       (sel && cmd_e'(cmd) == C_WR),
      .wra_i      (sel && cmd_e'(cmd) == C_WRA),
      .rda_i      (sel && cmd_e'(cmd) == C_RDA),
      .pre_i      ((sel && cmd_e'(cmd) == C_PRE) || is_prea),
      .open_o     (open_v[b]),
      .act_rdy_o  (act_rdy_v[b]),
      .rd_rdy_o   (rd_rdy_v[b]),
      .wr_rdy_o   (wr_rdy_v[b]),
      .pre_rdy_o  (pre_rdy_v[b]),
      .ras_over_o (ras_over_v[b])
    );
  end

  dcsg_global_timer #(
    .CW(CW), .RRD(RRD), .W2R(W2R), .MRD(MRD_CYC), .RFC(RFC),
    .REFI(REFI), .POSTPONE(REF_POSTPONE)
  ) u_glob (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_i      (is_act),
    .wr_i       (is_wr_any),
    .mrs_i      (is_mrs),
    .ref_i      (is_ref),
    .rrd_rdy_o  (rrd_rdy),
    .w2r_rdy_o  (w2r_rdy),
    .mrd_rdy_o  (mrd_rdy),
    .rfc_rdy_o  (rfc_rdy),
    .ref_late_o (ref_late)
  );

  dcsg_rule_check #(.NBANK(NBANK), .BW(BW)) u_rule (
    .cmd_i     (cmd),
    .bank_i    (bank),
    .open_i    (open_v),
    .act_rdy_i (act_rdy_v),
    .rd_rdy_i  (rd_rdy_v),
    .wr_rdy_i  (wr_rdy_v),
    .pre_rdy_i (pre_rdy_v),
    .rrd_rdy_i (rrd_rdy),
    .w2r_rdy_i (w2r_rdy),
    .mrd_rdy_i (mrd_rdy),
    .rfc_rdy_i (rfc_rdy),
    .allow_o   (allow),
    .code_o    (code_c)
  );

  // lowest-numbered bank wins when several overrun together
  logic          ras_any;
  logic [BW-1:0] ras_bank;
  always_comb begin
    ras_any  = 1'b0;
    ras_bank = '0;
    for (int b = NBANK - 1; b >= 0; b--) begin
      if (ras_over_v[b]) begin
        ras_any  = 1'b1;
        ras_bank = BW'(b);
      end
    end
  end

  logic          hit;
  logic [3:0]    hit_code;
  logic [BW-1:0] hit_bank;
  always_comb begin
    hit      = 1'b1;
    hit_code = 4'(code_c);
    hit_bank = bank;
    if (cmd_valid && code_c != V_NONE) begin
      hit = 1'b1;
    end else if (ras_any) begin
      hit_code = 4'(V_RAS_MAX);
      hit_bank = ras_bank;
    end else if (ref_late) begin
      hit_code = 4'(V_REF_LATE);
      hit_bank = '0;
    end else begin
      hit = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      viol      <= 1'b0;
      viol_code <= '0;
      viol_bank <= '0;
    end else if (!viol && hit) begin
      viol      <= 1'b1;
      viol_code <= hit_code;
      viol_bank <= hit_bank;
    end
  end

  p_flags_illegal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && code_c != V_NONE && !clr) |=> viol);
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !clr) |=> (viol && $stable(viol_code) && $stable(viol_bank)));
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!viol && viol_code == 4'd0));

endmodule

// File: tb/sim_dram_cmd_spacing_guard.sv
module sim_dram_cmd_spacing_guard;

  localparam int TCK = 4000;
  localparam logic [3:0] K_NOP = 4'd0, K_ACT = 4'd1, K_RD = 4'd2, K_RDA = 4'd3,
                         K_WR = 4'd4, K_WRA = 4'd5, K_PRE = 4'd6, K_REF = 4'd8,
                         K_MRS = 4'd9;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  localparam int N_RCDR  = cdiv(16000, TCK);
  localparam int N_RCDW  = (N_RCDR - 2 < 2) ? 2 : N_RCDR - 2;
  localparam int N_RRD   = cdiv(10000, TCK);
  localparam int N_RAS   = cdiv(32000, TCK);
  localparam int N_RP    = cdiv(16000, TCK);
  localparam int N_W2R   = 2 + 2;
  localparam int N_WRPRE = 2 + cdiv(15000, TCK);
  localparam int N_WRA   = 2 + 3 + N_RP;
  localparam int N_MRD   = 2;
  localparam int N_RFC   = cdiv(56000, TCK);
  localparam int N_RMAX  = 40;
  localparam int N_REFI  = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [3:0] cmd = K_NOP;
  logic [1:0] bank = 2'd0;
  logic clr = 1'b0;
  logic [9:0] allow;
  logic viol;
  logic [3:0] viol_code;
  logic [1:0] viol_bank;

  int checks = 0;
  int errors = 0;
  logic last_allow;

  always #2.5ns clk = ~clk;

  dram_cmd_spacing_guard #(
    .TRAS_MAX_PS(N_RMAX * TCK), .TREFI_PS(N_REFI * TCK), .REF_POSTPONE(2)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .bank(bank),
    .clr(clr), .allow(allow), .viol(viol), .viol_code(viol_code), .viol_bank(viol_bank)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    cmd_valid = 1'b0; cmd = K_NOP; clr = 1'b0;
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic send(input logic [3:0] c, input logic [1:0] b);
    cmd = c; bank = b; cmd_valid = 1'b1;
    #1;
    last_allow = allow[c];
    @(negedge clk);
    cmd_valid = 1'b0; cmd = K_NOP;
  endtask

  task automatic sweep(input string req, input logic [3:0] c1, input logic [1:0] b1,
                       input logic [3:0] c2, input logic [1:0] b2, input int n,
                       input int code, input bit pre_act);
    for (int k = 1; k <= n + 1; k++) begin
      do_reset();
      if (pre_act) begin
        send(K_ACT, b1);
        idle(11);
      end
      send(c1, b1);
      idle(k - 1);
      send(c2, b2);
      chk(req, $sformatf("allow gap %0d", k), int'(last_allow), (k >= n) ? 1 : 0);
      chk(req, $sformatf("viol gap %0d", k), int'(viol), (k < n) ? 1 : 0);
      chk(req, $sformatf("code gap %0d", k), int'(viol_code), (k < n) ? code : 0);
    end
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10 reset state, R2 idle banks refuse column commands
    do_reset();
    chk("R10", "viol after reset", int'(viol), 0);
    chk("R10", "code after reset", int'(viol_code), 0);
    chk("R1", "allow NOP", int'(allow[0]), 1);
    bank = 2'd0; #1;
    chk("R2", "allow ACT idle", int'(allow[1]), 1);
    chk("R2", "allow RD idle", int'(allow[2]), 0);

    // R2 state rules
    do_reset();
    send(K_RD, 2'd1);
    chk("R2", "RD idle code", int'(viol_code), 2);
    chk("R10", "bank of violation", int'(viol_bank), 1);
    do_reset();
    send(K_ACT, 2'd0); idle(4); send(K_ACT, 2'd0);
    chk("R2", "ACT open code", int'(viol_code), 1);
    do_reset();
    send(K_PRE, 2'd2); send(K_ACT, 2'd2);
    chk("R2", "PRE idle ignored", int'(viol), 0);

    // spacing sweeps
    sweep("R3", K_ACT, 2'd0, K_RD, 2'd0, N_RCDR, 5, 1'b0);
    sweep("R3", K_ACT, 2'd1, K_WR, 2'd1, N_RCDW, 5, 1'b0);
    sweep("R4", K_ACT, 2'd0, K_ACT, 2'd3, N_RRD, 4, 1'b0);
    sweep("R5", K_ACT, 2'd2, K_PRE, 2'd2, N_RAS, 7, 1'b0);
    sweep("R5", K_PRE, 2'd0, K_ACT, 2'd0, N_RP, 3, 1'b1);
    sweep("R5", K_RDA, 2'd1, K_ACT, 2'd1, N_RP, 3, 1'b1);
    sweep("R6", K_WR, 2'd0, K_RD, 2'd0, N_W2R, 6, 1'b1);
    sweep("R7", K_WR, 2'd3, K_PRE, 2'd3, N_WRPRE, 7, 1'b1);
    sweep("R7", K_WRA, 2'd2, K_ACT, 2'd2, N_WRA, 3, 1'b1);
    sweep("R8", K_PRE, 2'd0, K_MRS, 2'd0, N_RP, 8, 1'b1);
    sweep("R8", K_MRS, 2'd0, K_ACT, 2'd1, N_MRD, 9, 1'b0);
    sweep("R9", K_REF, 2'd0, K_ACT, 2'd1, N_RFC, 10, 1'b0);

    // R6 reads back to back
    do_reset();
    send(K_ACT, 2'd0); idle(11);
    send(K_RD, 2'd0); send(K_RD, 2'd0); send(K_RD, 2'd0);
    chk("R6", "reads back to back", int'(viol), 0);

    // R8, R9 with a bank open
    do_reset();
    send(K_ACT, 2'd3); idle(11); send(K_MRS, 2'd0);
    chk("R8", "MRS with open bank", int'(viol_code), 8);
    do_reset();
    send(K_ACT, 2'd1); idle(11); send(K_REF, 2'd0);
    chk("R9", "REF with open bank", int'(viol_code), 8);

    // R10 sticky and clear
    do_reset();
    send(K_RD, 2'd1);
    send(K_ACT, 2'd0); send(K_ACT, 2'd0);
    chk("R10", "first code kept", int'(viol_code), 2);
    chk("R10", "first bank kept", int'(viol_bank), 1);
    clr = 1'b1; idle(1); clr = 1'b0;
    chk("R10", "clear flag", int'(viol), 0);
    chk("R10", "clear code", int'(viol_code), 0);
    send(K_WR, 2'd3);
    chk("R10", "new code after clear", int'(viol_code), 2);
    chk("R10", "new bank after clear", int'(viol_bank), 3);

    // R11 open-time limit
    do_reset();
    send(K_ACT, 2'd2);
    idle(N_RMAX);
    chk("R11", "not yet over", int'(viol), 0);
    idle(1);
    chk("R11", "over flag", int'(viol), 1);
    chk("R11", "over code", int'(viol_code), 11);
    chk("R11", "over bank", int'(viol_bank), 2);
    do_reset();
    send(K_ACT, 2'd1); idle(N_RMAX - 1); send(K_PRE, 2'd1); idle(5);
    chk("R11", "closed in time", int'(viol), 0);

    // R12 refresh credit
    do_reset();
    idle(3 * N_REFI - 5);
    chk("R12", "credit not exceeded", int'(viol), 0);
    idle(10);
    chk("R12", "late flag", int'(viol), 1);
    chk("R12", "late code", int'(viol_code), 12);
    do_reset();
    for (int i = 0; i < 5; i++) begin
      idle(N_REFI - 10);
      send(K_REF, 2'd0);
    end
    chk("R12", "regular refresh", int'(viol), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule